// File: doc/BRIEF.md
# Exposed-Pipeline Write-Back Queue

This block decides which register gets written, and with what, in a microcoded engine that has no interlocks. Every issued instruction that produces a value drops that value into a small ring of slots. The slot is chosen by how many cycles the operation takes to finish. Every issued instruction also retires the slot at the head of the ring. The value from that slot goes to whichever destination the *current* instruction names. So a destination field names where the value finishing this cycle goes, not where the instruction's own result goes. The microcode compiler is responsible for lining producers and destinations up.

The ring is as deep as the longest latency, seven slots by default, and its head wraps around. After the retire step, the head slot is cleared and the head moves on by one. A producing instruction then lands in the slot that its latency selects. Two instruction kinds are special. A no-operation instruction retires and advances but schedules nothing. A vector-output instruction leaves the ring untouched. Two saturating counters record misuse. One counts results that overwrite a still-pending result. The other counts pending results that are thrown away because the retiring instruction names no destination.

Top module: `xpipe_wbq`

## Requirements
- R1: After reset, both counters read zero, every slot is empty and the head is at slot 0, so the first retirement into a nonzero destination writes zero.
- R2: While `issue_i` is high and the opcode is not vector-output (7), `rf_we_o` is high exactly when `dest_i` is nonzero. `rf_waddr_o` equals `dest_i`, and `rf_wdata_o` carries the head slot's value, all in the same cycle.
- R3: A producing instruction with latency L (1 to 7) has its result delivered to the destination of the L-th advancing instruction issued after it.
- R4: A retired slot is cleared, and retiring an empty slot into a nonzero destination writes zero.
- R5: An issued vector-output instruction (opcode 7) never raises `rf_we_o`, does not move the head and schedules nothing.
- R6: An issued no-operation instruction (opcode 0) retires and advances like any other instruction, but its `result_i` never reaches the register file.
- R7: A latency of 0 is treated as 1, and a latency above 7 is treated as 7.
- R8: When a result is scheduled into a slot that still holds a pending result, the newer value replaces it and the collision counter increments by one.
- R9: When an instruction with destination 0 retires a slot holding a pending result, the stray counter increments by one.
- R10: Cycles with `issue_i` low write nothing, move nothing and leave both counters unchanged.
- R11: Both counters stop at their all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| issue_i | input | 1 | Instruction issue strobe |
| opcode_i | input | 4 | Opcode of the issued instruction (0 no-operation, 7 vector-output) |
| latency_i | input | 4 | Completion latency of the issued operation |
| result_i | input | 32 | Result value of the issued operation |
| dest_i | input | 7 | Destination field of the issued instruction |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 7 | Register-file write address |
| rf_wdata_o | output | 32 | Register-file write data |
| collisions_o | output | 16 | Saturating count of overwritten pending results |
| strays_o | output | 16 | Saturating count of discarded pending results |

## Verification
Producers are issued at every latency from 1 to 7, each followed by a chain of no-operation retirements. This shows whether a result lands exactly L advances later, and not one slot early or late. Vector-output and idle cycles are placed between a producer and its consumer. This separates "no advance" from "advance without write". A no-operation instruction with a non-zero result tells scheduling apart from retiring. Pairs of producers with staggered latencies that aim at the same slot, and retirements with destination 0 over full slots, drive each counter. The pairs are repeated long enough to reach saturation on a narrow counter instance. A latency-7 producer that reuses the slot just freed checks that this reuse is not counted as a collision.

// File: rtl/wbq_pkg.sv
package wbq_pkg;
   // Opcode values the neighbouring decoder also uses
   localparam int unsigned OPC_IDLE = 0;   // no-operation: retire only
   localparam int unsigned OPC_VECT = 7;   // vector output: ring untouched

   // Default ring depth equals the longest operation latency
   localparam int unsigned MAX_LAT  = 7;
endpackage

// File: rtl/wbq_sat_counter.sv
module wbq_sat_counter #(
   parameter int unsigned W        = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   if (W < 1) begin : g_bad_w
      $error("wbq_sat_counter: W must be at least 1");
   end

   localparam logic [W-1:0] CNT_MAX = '1;

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           cnt_o <= '0;
         else if (inc_i && cnt_o != CNT_MAX)   cnt_o <= cnt_o + 1'b1;
      end

      AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> cnt_o >= $past(cnt_o)); // R11

      AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         !inc_i |=> $stable(cnt_o)); // R10
   end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     cnt_o <= '0;
         else if (inc_i) cnt_o <= cnt_o + 1'b1;
      end
   end
endmodule

// File: rtl/wbq_target.sv
module wbq_target #(
   parameter int unsigned SLOTS  = 7,
   parameter int unsigned LAT_W  = 4,
   parameter int unsigned HEAD_W = 3
) (
   input  logic [HEAD_W-1:0] head_i,
   input  logic [LAT_W-1:0]  lat_i,
   output logic [HEAD_W-1:0] idx_o
);
   localparam int unsigned SUM_W = HEAD_W + 1;

   logic [LAT_W-1:0] lat_c;
   logic [SUM_W-1:0] sum;

   // Clamp latency into 1..SLOTS
   always_comb begin
      if (lat_i == '0)               lat_c = LAT_W'(1);
      else if (int'(lat_i) > SLOTS)  lat_c = LAT_W'(SLOTS);
      else                           lat_c = lat_i;
   end

   // Slot relative to the pre-advance head: (head + 1) + (lat - 1)
   always_comb begin
      sum   = SUM_W'(head_i) + SUM_W'(lat_c);
      idx_o = (sum >= SUM_W'(SLOTS)) ? HEAD_W'(sum - SUM_W'(SLOTS)) : HEAD_W'(sum);
   end

   always_comb begin
      AST_TARGET_RANGE: assert (int'(idx_o) < SLOTS || int'(head_i) >= SLOTS); // R7
   end
endmodule

// File: rtl/wbq_slot_ring.sv
module wbq_slot_ring #(
   parameter int unsigned SLOTS  = 7,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned HEAD_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_i,
   input  logic              put_i,
   input  logic [HEAD_W-1:0] put_idx_i,
   input  logic [DATA_W-1:0] put_data_i,
   output logic [HEAD_W-1:0] head_o,
   output logic [DATA_W-1:0] head_data_o,
   output logic              head_occ_o,
   output logic [SLOTS-1:0]  occ_o
);
   logic [DATA_W-1:0] slot_q [SLOTS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         head_o <= '0;
      else if (adv_i)
         head_o <= (head_o == HEAD_W'(SLOTS - 1)) ? '0 : head_o + 1'b1;
   end

   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q[k] <= '0;
            occ_o[k]  <= 1'b0;
         end else if (put_i && put_idx_i == HEAD_W'(k)) begin
            slot_q[k] <= put_data_i;
            occ_o[k]  <= 1'b1;
         end else if (adv_i && head_o == HEAD_W'(k)) begin
            slot_q[k] <= '0;
            occ_o[k]  <= 1'b0;
         end
      end
   end

   assign head_data_o = slot_q[head_o];
   assign head_occ_o  = occ_o[head_o];

   AST_HEAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(head_o) < SLOTS); // R3

   AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> $stable(head_o)); // R5

   AST_RETIRED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i && !put_i |=> !occ_o[$past(head_o)]); // R4
endmodule

// File: rtl/xpipe_wbq.sv
module xpipe_wbq #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned DEST_W    = 7,
   parameter int unsigned OP_W      = 4,
   parameter int unsigned LAT_W     = 4,
   parameter int unsigned SLOTS     = wbq_pkg::MAX_LAT,
   parameter int unsigned CNT_W     = 16,
   parameter bit          SAT_COUNT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_i,
   input  logic [OP_W-1:0]   opcode_i,
   input  logic [LAT_W-1:0]  latency_i,
   input  logic [DATA_W-1:0] result_i,
   input  logic [DEST_W-1:0] dest_i,
   output logic              rf_we_o,
   output logic [DEST_W-1:0] rf_waddr_o,
   output logic [DATA_W-1:0] rf_wdata_o,
   output logic [CNT_W-1:0]  collisions_o,
   output logic [CNT_W-1:0]  strays_o
);
   import wbq_pkg::*;

   localparam int unsigned HEAD_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

   if (SLOTS < 2) begin : g_bad_slots
      $error("xpipe_wbq: SLOTS must be at least 2");
   end
   if ((1 << LAT_W) <= SLOTS) begin : g_bad_lat
      $error("xpipe_wbq: LAT_W too narrow for SLOTS");
   end
   if ((1 << OP_W) <= OPC_VECT) begin : g_bad_op
      $error("xpipe_wbq: OP_W too narrow for opcode values");
   end

   logic              is_vect, is_idle, advance, produce;
   logic              collide, stray;
   logic [HEAD_W-1:0] head, target;
   logic [DATA_W-1:0] head_data;
   logic              head_occ;
   logic [SLOTS-1:0]  occ;

   assign is_vect = (opcode_i == OP_W'(OPC_VECT));
   assign is_idle = (opcode_i == OP_W'(OPC_IDLE));
   assign advance = issue_i && !is_vect;
   assign produce = advance && !is_idle;

   wbq_target #(.SLOTS(SLOTS), .LAT_W(LAT_W), .HEAD_W(HEAD_W)) u_target (
      .head_i (head),
      .lat_i  (latency_i),
      .idx_o  (target)
   );

   wbq_slot_ring #(.SLOTS(SLOTS), .DATA_W(DATA_W), .HEAD_W(HEAD_W)) u_ring (
      .clk         (clk),
      .rst_n       (rst_n),
      .adv_i       (advance),
      .put_i       (produce),
      .put_idx_i   (target),
      .put_data_i  (result_i),
      .head_o      (head),
      .head_data_o (head_data),
      .head_occ_o  (head_occ),
      .occ_o       (occ)
   );

   // The head slot is cleared before the new result lands, so a full-latency
   // result reusing the head slot is not a collision
   assign collide = produce && occ[target] && (target != head);
   assign stray   = advance && (dest_i == '0) && head_occ;

   wbq_sat_counter #(.W(CNT_W), .SATURATE(SAT_COUNT)) u_coll (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (collide),
      .cnt_o (collisions_o)
   );

   wbq_sat_counter #(.W(CNT_W), .SATURATE(SAT_COUNT)) u_stray (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (stray),
      .cnt_o (strays_o)
   );

   assign rf_we_o    = advance && (dest_i != '0);
   assign rf_waddr_o = dest_i;
   assign rf_wdata_o = head_data;

   AST_VECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i && is_vect |-> !rf_we_o); // R5

   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_i |-> !rf_we_o); // R10

   AST_IDLE_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_i |=> $stable(occ)); // R10

   AST_PUT_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
      produce |=> occ[$past(target)]); // R8

   AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !head_occ |-> rf_wdata_o == '0); // R4
endmodule

// File: tb/xpipe_wbq_bench.sv
module xpipe_wbq_bench;
   localparam int SL      = 7;
   localparam int CW      = 4;
   localparam int CNT_MAX = (1 << CW) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_i = 1'b0;
   logic [3:0]  opcode_i = '0;
   logic [3:0]  latency_i = '0;
   logic [31:0] result_i = '0;
   logic [6:0]  dest_i = '0;
   logic        rf_we_o;
   logic [6:0]  rf_waddr_o;
   logic [31:0] rf_wdata_o;
   logic [CW-1:0] collisions_o, strays_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   // reference state built from the requirements
   logic [31:0] m_data [SL];
   bit          m_occ  [SL];
   int          m_head, m_coll, m_stray;

   always #4 clk = ~clk;

   xpipe_wbq #(.CNT_W(CW)) u_xpipe_wbq (
      .clk          (clk),
      .rst_n        (rst_n),
      .issue_i      (issue_i),
      .opcode_i     (opcode_i),
      .latency_i    (latency_i),
      .result_i     (result_i),
      .dest_i       (dest_i),
      .rf_we_o      (rf_we_o),
      .rf_waddr_o   (rf_waddr_o),
      .rf_wdata_o   (rf_wdata_o),
      .collisions_o (collisions_o),
      .strays_o     (strays_o)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int k = 0; k < SL; k++) begin m_data[k] = '0; m_occ[k] = 0; end
      m_head = 0; m_coll = 0; m_stray = 0;
   endtask

   task automatic check_counters(input string tag);
      check(collisions_o == CW'(m_coll), {tag, " collisions"}, collisions_o, m_coll);
      check(strays_o == CW'(m_stray), {tag, " strays"}, strays_o, m_stray);
   endtask

   // Issue one instruction, check the write port, step, update model, check counters
   task automatic do_issue(input int op, input int lat, input logic [31:0] res,
                           input int dst, input string tag);
      bit          exp_we;
      logic [31:0] exp_d;
      int          le, t;
      @(negedge clk);
      issue_i = 1'b1; opcode_i = 4'(op); latency_i = 4'(lat);
      result_i = res; dest_i = 7'(dst);
      #1;
      exp_we = (op != 7) && (dst != 0);
      exp_d  = m_data[m_head];
      check(rf_we_o == exp_we, {tag, " write enable"}, rf_we_o, exp_we);
      if (exp_we) begin
         check(rf_waddr_o == 7'(dst), {tag, " write address"}, rf_waddr_o, dst);
         check(rf_wdata_o == exp_d, {tag, " write data"}, rf_wdata_o, exp_d);
      end
      @(posedge clk); #1;
      issue_i = 1'b0;
      if (op != 7) begin
         if (dst == 0 && m_occ[m_head] && m_stray < CNT_MAX) m_stray++;
         m_data[m_head] = '0; m_occ[m_head] = 0;
         m_head = (m_head + 1) % SL;
         if (op != 0) begin
            le = (lat == 0) ? 1 : ((lat > SL) ? SL : lat);
            t  = (m_head + le - 1) % SL;
            if (m_occ[t] && m_coll < CNT_MAX) m_coll++;
            m_data[t] = res; m_occ[t] = 1;
         end
      end
      check_counters(tag);
   endtask

   task automatic expect_next(input logic [31:0] exp, input string tag);
      @(negedge clk);
      issue_i = 1'b1; opcode_i = 4'd0; latency_i = 4'd1; result_i = 32'hFFFF_FFFF; dest_i = 7'd33;
      #1;
      check(rf_wdata_o == exp, {tag, " direct value"}, rf_wdata_o, exp);
      @(posedge clk); #1;
      issue_i = 1'b0;
      m_data[m_head] = '0; m_occ[m_head] = 0;
      m_head = (m_head + 1) % SL;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; issue_i = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      model_reset();
      @(negedge clk);
      check(rf_we_o == 1'b0, "R1 idle write after reset", rf_we_o, 0);
      check_counters("R1 reset");
      do_issue(0, 1, 32'h0, 12, "R1 first retire");
      check(1'b1, "R1", 0, 0);
   endtask

   task automatic t_latency();
      for (int lat = 1; lat <= 7; lat++) begin
         do_issue(1, lat, 32'hA000_0000 + 32'(lat), 0, "R3 producer");
         for (int n = 1; n < lat; n++) do_issue(0, 1, 32'h0, 0, "R3 filler");
         expect_next(32'hA000_0000 + 32'(lat), "R3 latency delivery");
      end
      do_issue(2, 2, 32'h1111_2222, 5, "R2 producer with destination");
      do_issue(0, 1, 32'h0, 6, "R2 consumer");
   endtask

   task automatic t_clear();
      do_issue(3, 1, 32'h5A5A_0001, 0, "R4 producer");
      do_issue(0, 1, 32'h0, 9, "R4 consume");
      for (int n = 0; n < 6; n++) do_issue(0, 1, 32'h0, 0, "R4 walk");
      expect_next(32'h0, "R4 cleared slot reads zero");
   endtask

   task automatic t_nop();
      do_issue(0, 1, 32'hDEAD_BEEF, 3, "R6 nop with result");
      for (int n = 0; n < 7; n++) do_issue(0, 1, 32'h0, 3, "R6 nop result absent");
   endtask

   task automatic t_vect();
      do_issue(4, 2, 32'hC0DE_0002, 0, "R5 producer");
      do_issue(7, 1, 32'hBAD0_0007, 4, "R5 vector no write");
      do_issue(7, 1, 32'hBAD0_0008, 4, "R5 vector again");
      expect_next(32'h0, "R5 no advance by vector");
      expect_next(32'hC0DE_0002, "R5 result after vectors");
      for (int n = 0; n < 7; n++) do_issue(0, 1, 32'h0, 4, "R5 vector result absent");
   endtask

   task automatic t_clamp();
      do_issue(5, 0, 32'h0C1A_0000, 0, "R7 latency zero");
      expect_next(32'h0C1A_0000, "R7 zero acts as one");
      do_issue(5, 12, 32'h0C1A_000C, 0, "R7 latency twelve");
      for (int n = 0; n < 6; n++) do_issue(0, 1, 32'h0, 0, "R7 filler");
      expect_next(32'h0C1A_000C, "R7 twelve acts as seven");
   endtask

   task automatic t_collision();
      int c0;
      c0 = m_coll;
      do_issue(1, 3, 32'hAAAA_0003, 0, "R8 first");
      do_issue(1, 2, 32'hBBBB_0002, 0, "R8 second same slot");
      check(int'(collisions_o) == c0 + 1, "R8 counter step", collisions_o, c0 + 1);
      expect_next(32'h0, "R8 gap");
      expect_next(32'hBBBB_0002, "R8 newer wins");
      do_issue(1, 7, 32'h7777_0007, 0, "R8 full latency reuse");
      check(int'(collisions_o) == c0 + 1, "R8 reuse not collision", collisions_o, c0 + 1);
      for (int n = 0; n < 7; n++) do_issue(0, 1, 32'h0, 2, "R8 drain");
   endtask

   task automatic t_stray();
      int s0;
      do_issue(2, 1, 32'h5700_0001, 0, "R9 producer");
      s0 = m_stray;
      do_issue(0, 1, 32'h0, 0, "R9 discard");
      check(int'(strays_o) == s0 + 1, "R9 stray step", strays_o, s0 + 1);
      do_issue(0, 1, 32'h0, 0, "R9 empty discard");
      check(int'(strays_o) == s0 + 1, "R9 empty not stray", strays_o, s0 + 1);
   endtask

   task automatic t_idle();
      do_issue(6, 2, 32'h1D1E_0002, 0, "R10 producer");
      for (int n = 0; n < 5; n++) begin
         @(negedge clk);
         issue_i = 1'b0; opcode_i = 4'd1; latency_i = 4'd1; result_i = 32'hEEEE_0000; dest_i = 7'd8;
         #1;
         check(rf_we_o == 1'b0, "R10 idle no write", rf_we_o, 0);
         @(posedge clk); #1;
         check_counters("R10 idle");
      end
      expect_next(32'h0, "R10 idle no advance");
      expect_next(32'h1D1E_0002, "R10 result survives idle");
   endtask

   task automatic t_saturate();
      for (int n = 0; n < 20; n++) begin
         do_issue(1, 3, 32'(n), 0, "R11 pair a");
         do_issue(1, 2, 32'(n) + 32'h100, 0, "R11 pair b");
      end
      check(int'(collisions_o) == CNT_MAX, "R11 collisions saturated", collisions_o, CNT_MAX);
      check(int'(strays_o) == CNT_MAX, "R11 strays saturated", strays_o, CNT_MAX);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_latency();
      t_clear();
      t_nop();
      t_vect();
      t_clamp();
      t_collision();
      t_stray();
      t_idle();
      t_saturate();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule